// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Update

This block carries out the data operations of a small 8-bit processor. A register value arrives on `opnd_a`, a second value (a memory cell's content or an immediate constant, already fetched by the caller) arrives on `opnd_b`, and a 4-bit operation code plus a unary/binary selector choose the operation. The block returns the byte to be written back, a write-enable for that destination, a flag-update enable and a divide-by-zero error. All of these are combinational.

A status register inside the block holds the zero, negative, overflow and carry bits for later conditional branches. It is rewritten on a clock edge only when the selected operation is one that is defined to affect the flags. Moves, multiply, divide and modulo leave it untouched. Compare affects the flags but does not write a result.

Top module: `alu8_core`

## Requirements
- R1: With `unary`=0, code 1 (load) returns `opnd_b` and code 2 (store) returns `opnd_a`. Both raise `dest_we`, and neither raises `flag_we`.
- R2: With `unary`=0, code 3 (add) returns A+B and code 4 (sub) returns A-B, both modulo 256, with `dest_we`=1 and `flag_we`=1. For add, c is the carry out. For sub, c is set on borrow (A<B unsigned). v is set on signed overflow.
- R3: Code 5 (compare) produces the same result byte and flags as sub, but `dest_we` is 0 and `flag_we` is 1.
- R4: Codes 6, 7 and 8 return A AND B, A OR B and A XOR B, with `dest_we`=1 and `flag_we`=1. The c and v flags are cleared.
- R5: Code 9 returns the low byte of the signed 8x8 product, with `dest_we`=1 and `flag_we`=0.
- R6: Code A returns the signed quotient truncated toward zero. Code B returns the remainder, which takes the dividend's sign. Both have `dest_we`=1 and `flag_we`=0. The case -128 / -1 returns 0x80.
- R7: For codes A and B, a zero `opnd_b` returns 0 and raises `div_err`, with `dest_we`=1 and `flag_we`=0. `div_err` is 0 for every other case.
- R8: With `unary`=1, code 2 returns A+1, code 3 returns A-1 and code 4 returns 0-A (two's complement). All three raise `dest_we` and `flag_we`. c is the carry for increment and the borrow for the other two. v is set on signed overflow.
- R9: `flag_q` is laid out as c in bit 0, v in bit 1, n in bit 2, z in bit 3, with bits 7..4 zero. z means the result is zero and n is result bit 7. On the clock edge where `flag_we` is 1, the new flags are loaded into `flag_q`. The register keeps its value when `flag_we` is 0, and a synchronous active-low reset clears it.
- R10: Any undefined code (binary 0 or C..F, unary other than 2..4) returns 0 with `dest_we`, `flag_we` and `div_err` all 0, and leaves `flag_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| unary | input | 1 | 1 selects the unary operation set |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | Register operand |
| opnd_b | input | 8 | Second operand (ignored by unary operations) |
| result | output | 8 | Result byte |
| dest_we | output | 1 | Destination write-enable |
| flag_we | output | 1 | Flag update enable for this operation |
| div_err | output | 1 | Divide or modulo by zero |
| flag_q | output | 8 | Registered flags {0000,z,n,v,c} |

## Verification
The properties assume that `unary`, `op_sel` and both operands are known and held steady across each rising edge, because the flag register captures whatever the combinational path presents at that edge. The bench meets this by changing inputs only on falling edges and holding them for a full cycle. It also keeps each operation on the inputs until the flag register has been sampled, so the capture properties always compare against the operation that was actually loaded.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes, result-source selector and flag bit
// positions for the byte ALU. Assumes 4-bit operation codes.
package alu8_pkg;

    typedef enum logic [3:0] {
        BOP_LOAD  = 4'h1,
        BOP_STORE = 4'h2,
        BOP_ADD   = 4'h3,
        BOP_SUB   = 4'h4,
        BOP_CMP   = 4'h5,
        BOP_AND   = 4'h6,
        BOP_OR    = 4'h7,
        BOP_XOR   = 4'h8,
        BOP_MUL   = 4'h9,
        BOP_DIV   = 4'hA,
        BOP_MOD   = 4'hB
    } bin_op_e;

    typedef enum logic [3:0] {
        UOP_INC = 4'h2,
        UOP_DEC = 4'h3,
        UOP_NEG = 4'h4
    } un_op_e;

    typedef enum logic [3:0] {
        SRC_NONE,
        SRC_B,
        SRC_A,
        SRC_ARITH,
        SRC_AND,
        SRC_OR,
        SRC_XOR,
        SRC_MUL,
        SRC_DIV,
        SRC_MOD
    } res_src_e;

    localparam int FLAG_C = 0;
    localparam int FLAG_V = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_Z = 3;

endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor with carry-or-borrow and signed overflow.
// Assumes two's-complement operands of width W; for subtraction the
// carry output reports a borrow (x < y unsigned).
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cflag,
    output logic         vflag
);
    logic [W-1:0] y_eff;
    logic [W:0]   raw;

    // Invert the second operand and inject a carry for subtraction.
    always_comb begin
        y_eff = sub ? ~y : y;
        raw   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
        sum   = raw[W-1:0];
        cflag = sub ? ~raw[W] : raw[W];
        vflag = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu8_muldiv.sv
// Signed multiply (low half kept), signed divide and remainder.
// Division truncates toward zero, and the remainder takes the dividend's
// sign. A zero divisor yields zero outputs and raises zero_div.
module alu8_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         zero_div
);
    logic signed [W-1:0] prod;
    logic signed [W:0]   dvd;
    logic signed [W:0]   dvs;
    logic signed [W:0]   q_full;
    logic signed [W:0]   r_full;
    logic                unused_hi;

    // Widen by one bit so that the most negative value divided by -1 does not wrap early.
    always_comb begin
        zero_div  = (b == '0);
        prod      = $signed(a) * $signed(b);
        dvd       = {a[W-1], a};
        dvs       = zero_div ? (W+1)'(1) : {b[W-1], b};
        q_full    = dvd / dvs;
        r_full    = dvd % dvs;
        prod_lo   = prod;
        quot      = zero_div ? '0 : q_full[W-1:0];
        rem       = zero_div ? '0 : r_full[W-1:0];
        unused_hi = q_full[W] ^ r_full[W];
    end
endmodule

// File: rtl/alu8_ctl.sv
// Decodes the operation select into the result source, the adder setup and
// the per-operation write and flag-update enables. Undefined codes decode
// to no source and no enables.
module alu8_ctl
    import alu8_pkg::*;
(
    input  logic     unary,
    input  logic [3:0] op_sel,
    output res_src_e src,
    output logic     add_sub,
    output logic     y_one,
    output logic     x_zero,
    output logic     logic_op,
    output logic     dest_we,
    output logic     flag_we
);
    // Per-operation decode table.
    always_comb begin
        src      = SRC_NONE;
        add_sub  = 1'b0;
        y_one    = 1'b0;
        x_zero   = 1'b0;
        logic_op = 1'b0;
        dest_we  = 1'b0;
        flag_we  = 1'b0;
        if (unary) begin
            case (op_sel)
                UOP_INC: begin src = SRC_ARITH; y_one = 1'b1; dest_we = 1'b1; flag_we = 1'b1; end
                UOP_DEC: begin src = SRC_ARITH; y_one = 1'b1; add_sub = 1'b1; dest_we = 1'b1; flag_we = 1'b1; end
                UOP_NEG: begin src = SRC_ARITH; x_zero = 1'b1; add_sub = 1'b1; dest_we = 1'b1; flag_we = 1'b1; end
                default: ;
            endcase
        end else begin
            case (op_sel)
                BOP_LOAD:  begin src = SRC_B; dest_we = 1'b1; end
                BOP_STORE: begin src = SRC_A; dest_we = 1'b1; end
                BOP_ADD:   begin src = SRC_ARITH; dest_we = 1'b1; flag_we = 1'b1; end
                BOP_SUB:   begin src = SRC_ARITH; add_sub = 1'b1; dest_we = 1'b1; flag_we = 1'b1; end
                BOP_CMP:   begin src = SRC_ARITH; add_sub = 1'b1; flag_we = 1'b1; end
                BOP_AND:   begin src = SRC_AND; logic_op = 1'b1; dest_we = 1'b1; flag_we = 1'b1; end
                BOP_OR:    begin src = SRC_OR;  logic_op = 1'b1; dest_we = 1'b1; flag_we = 1'b1; end
                BOP_XOR:   begin src = SRC_XOR; logic_op = 1'b1; dest_we = 1'b1; flag_we = 1'b1; end
                BOP_MUL:   begin src = SRC_MUL; dest_we = 1'b1; end
                BOP_DIV:   begin src = SRC_DIV; dest_we = 1'b1; end
                BOP_MOD:   begin src = SRC_MOD; dest_we = 1'b1; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/alu8_core.sv
// Byte ALU top: combinational datapath plus a registered flag byte.
// Assumes inputs are stable around each rising clock edge. The flag register
// loads {z,n,v,c} only when the decoded operation enables flag update.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unary,
    input  logic [3:0]    op_sel,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    output logic [W-1:0]  result,
    output logic          dest_we,
    output logic          flag_we,
    output logic          div_err,
    output logic [FW-1:0] flag_q
);
    localparam int NFLAG = 4;

    res_src_e     src;
    logic         add_sub, y_one, x_zero, logic_op;
    logic [W-1:0] as_x, as_y, as_sum, prod_lo, quot, rem;
    logic         as_c, as_v, zero_div;
    logic [NFLAG-1:0] flag_next;

    alu8_ctl u_ctl (
        .unary(unary), .op_sel(op_sel), .src(src), .add_sub(add_sub),
        .y_one(y_one), .x_zero(x_zero), .logic_op(logic_op),
        .dest_we(dest_we), .flag_we(flag_we)
    );

    // Adder operand steering for add/sub/cmp and the unary forms.
    always_comb begin
        as_x = x_zero ? '0 : opnd_a;
        as_y = x_zero ? opnd_a : (y_one ? W'(1) : opnd_b);
    end

    alu8_addsub #(.W(W)) u_addsub (
        .x(as_x), .y(as_y), .sub(add_sub), .sum(as_sum), .cflag(as_c), .vflag(as_v)
    );

    alu8_muldiv #(.W(W)) u_muldiv (
        .a(opnd_a), .b(opnd_b), .prod_lo(prod_lo), .quot(quot), .rem(rem), .zero_div(zero_div)
    );

    // Result selection.
    always_comb begin
        case (src)
            SRC_B:     result = opnd_b;
            SRC_A:     result = opnd_a;
            SRC_ARITH: result = as_sum;
            SRC_AND:   result = opnd_a & opnd_b;
            SRC_OR:    result = opnd_a | opnd_b;
            SRC_XOR:   result = opnd_a ^ opnd_b;
            SRC_MUL:   result = prod_lo;
            SRC_DIV:   result = quot;
            SRC_MOD:   result = rem;
            default:   result = '0;
        endcase
        div_err = ((src == SRC_DIV) || (src == SRC_MOD)) && zero_div;
    end

    // New flag values for the current operation.
    always_comb begin
        flag_next         = '0;
        flag_next[FLAG_Z] = (result == '0);
        flag_next[FLAG_N] = result[W-1];
        flag_next[FLAG_V] = logic_op ? 1'b0 : as_v;
        flag_next[FLAG_C] = logic_op ? 1'b0 : as_c;
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else if (flag_we)
            flag_q <= {{(FW-NFLAG){1'b0}}, flag_next};
    end
endmodule

// File: rtl/alu8_core_chk.sv
// Property checker for alu8_core, attached with bind. Assumes 8-bit data
// and the flag layout {0000,z,n,v,c}.
module alu8_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       unary,
    input logic [3:0] op_sel,
    input logic [7:0] opnd_a,
    input logic [7:0] opnd_b,
    input logic [7:0] result,
    input logic       dest_we,
    input logic       flag_we,
    input logic       div_err,
    input logic [7:0] flag_q
);
    a_r1_load_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!unary && op_sel == 4'h1) |-> (result == opnd_b && dest_we && !flag_we));

    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!unary && op_sel == 4'h5) |-> (!dest_we && flag_we));

    a_r4_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (!unary && (op_sel == 4'h6 || op_sel == 4'h7 || op_sel == 4'h8)) |=> (flag_q[1:0] == 2'b00));

    a_r5_mul_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!unary && op_sel == 4'h9) |=> $stable(flag_q));

    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (!unary && (op_sel == 4'hA || op_sel == 4'hB) && opnd_b == 8'h00) |-> (div_err && result == 8'h00));

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flag_q));

    a_r9_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flag_q[3] == ($past(result) == 8'h00) && flag_q[2] == $past(result[7]) && flag_q[7:4] == 4'h0));

    a_r10_undefined_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!unary && (op_sel == 4'h0 || op_sel >= 4'hC)) |-> (!dest_we && !flag_we && !div_err && result == 8'h00));
endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .unary(unary), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .dest_we(dest_we),
    .flag_we(flag_we), .div_err(div_err), .flag_q(flag_q)
);

// File: tb/tb_alu8_core.sv
// Directed bench for alu8_core: one task per scenario, each checking results
// against a reference model written from the requirements.
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unary = 1'b0;
    logic [3:0] op_sel = 4'h0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] result;
    logic       dest_we, flag_we, div_err;
    logic [7:0] flag_q;

    int checks = 0;
    int fails  = 0;
    logic [7:0] shadow_flags = 8'h00;

    always #2 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .unary(unary), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .dest_we(dest_we),
        .flag_we(flag_we), .div_err(div_err), .flag_q(flag_q)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    task automatic model(input logic u, input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         output logic [7:0] res, output logic we, output logic fwe,
                         output logic err, output logic c, output logic v);
        int sa, sb, ua, ub, t;
        sa = int'($signed(a)); sb = int'($signed(b)); ua = int'(a); ub = int'(b);
        res = 8'h00; we = 0; fwe = 0; err = 0; c = 0; v = 0;
        if (u) begin
            case (op)
                4'h2: begin res = 8'(ua + 1); we = 1; fwe = 1; c = (ua == 255); v = (sa + 1 > 127); end
                4'h3: begin res = 8'(ua - 1); we = 1; fwe = 1; c = (ua == 0); v = (sa - 1 < -128); end
                4'h4: begin res = 8'(-ua); we = 1; fwe = 1; c = (ua != 0); v = (-sa > 127); end
                default: ;
            endcase
        end else begin
            case (op)
                4'h1: begin res = b; we = 1; end
                4'h2: begin res = a; we = 1; end
                4'h3: begin t = ua + ub; res = 8'(t); we = 1; fwe = 1; c = (t > 255);
                            v = (sa + sb > 127) || (sa + sb < -128); end
                4'h4, 4'h5: begin res = 8'(ua - ub); we = (op == 4'h4); fwe = 1; c = (ua < ub);
                            v = (sa - sb > 127) || (sa - sb < -128); end
                4'h6: begin res = a & b; we = 1; fwe = 1; end
                4'h7: begin res = a | b; we = 1; fwe = 1; end
                4'h8: begin res = a ^ b; we = 1; fwe = 1; end
                4'h9: begin res = 8'(sa * sb); we = 1; end
                4'hA: begin we = 1; if (ub == 0) err = 1; else res = 8'(sa / sb); end
                4'hB: begin we = 1; if (ub == 0) err = 1; else res = 8'(sa % sb); end
                default: ;
            endcase
        end
    endtask

    // Apply one operation, check the combinational outputs, then the flag register.
    task automatic run(input string tag, input logic u, input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] e_res; logic e_we, e_fwe, e_err, e_c, e_v;
        model(u, op, a, b, e_res, e_we, e_fwe, e_err, e_c, e_v);
        @(negedge clk);
        unary = u; op_sel = op; opnd_a = a; opnd_b = b;
        #1;
        check(tag, "result", result, e_res);
        check(tag, "dest_we", dest_we, e_we);
        check(tag, "flag_we", flag_we, e_fwe);
        check(tag, "div_err", div_err, e_err);
        if (e_fwe)
            shadow_flags = {4'h0, (e_res == 8'h00), e_res[7], e_v, e_c};
        @(negedge clk);
        check(tag, "flag_q", flag_q, shadow_flags);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "flag_q after reset", flag_q, 8'h00);
        rst_n = 1'b1;
        shadow_flags = 8'h00;
    endtask

    task automatic t_moves;
        run("R1", 0, 4'h1, 8'h3C, 8'hA5);
        run("R1", 0, 4'h2, 8'h3C, 8'hA5);
    endtask

    task automatic t_addsub;
        run("R2", 0, 4'h3, 8'h03, 8'h14);
        run("R2", 0, 4'h3, 8'h7F, 8'h01);
        run("R2", 0, 4'h3, 8'hFF, 8'h01);
        run("R2", 0, 4'h4, 8'h05, 8'h07);
        run("R2", 0, 4'h4, 8'h80, 8'h01);
        run("R2", 0, 4'h4, 8'h42, 8'h42);
    endtask

    task automatic t_cmp;
        run("R3", 0, 4'h5, 8'h10, 8'h20);
        run("R3", 0, 4'h5, 8'h55, 8'h55);
    endtask

    task automatic t_logic;
        run("R2", 0, 4'h3, 8'hFF, 8'h81);
        run("R4", 0, 4'h6, 8'hF0, 8'h3C);
        run("R4", 0, 4'h7, 8'h80, 8'h01);
        run("R4", 0, 4'h8, 8'hAA, 8'hAA);
    endtask

    task automatic t_mul;
        run("R2", 0, 4'h3, 8'h7F, 8'h01);
        run("R5", 0, 4'h9, 8'hFF, 8'h02);
        check("R5", "mul -1*2 byte", result, 8'hFE);
        run("R5", 0, 4'h9, 8'h10, 8'h10);
        run("R5", 0, 4'h9, 8'hF9, 8'hFD);
    endtask

    task automatic t_divmod;
        run("R6", 0, 4'hA, 8'hF9, 8'h02);
        check("R6", "div -7/2", result, 8'hFD);
        run("R6", 0, 4'hB, 8'hF9, 8'h02);
        check("R6", "mod -7%2", result, 8'hFF);
        run("R6", 0, 4'hB, 8'h07, 8'hFE);
        run("R6", 0, 4'hA, 8'h80, 8'hFF);
        check("R6", "div -128/-1", result, 8'h80);
        run("R6", 0, 4'hB, 8'h80, 8'hFF);
    endtask

    task automatic t_divzero;
        run("R7", 0, 4'hA, 8'h33, 8'h00);
        run("R7", 0, 4'hB, 8'h85, 8'h00);
    endtask

    task automatic t_unary;
        run("R8", 1, 4'h2, 8'h7F, 8'h00);
        run("R8", 1, 4'h2, 8'hFF, 8'h12);
        run("R8", 1, 4'h3, 8'h00, 8'h00);
        run("R8", 1, 4'h3, 8'h80, 8'h00);
        run("R8", 1, 4'h4, 8'h80, 8'h00);
        run("R8", 1, 4'h4, 8'h05, 8'h00);
        run("R8", 1, 4'h4, 8'h00, 8'h00);
    endtask

    task automatic t_undefined;
        run("R2", 0, 4'h4, 8'h01, 8'h02);
        run("R10", 0, 4'h0, 8'h12, 8'h34);
        run("R10", 0, 4'hF, 8'h12, 8'h34);
        run("R10", 1, 4'h0, 8'h12, 8'h34);
        run("R10", 1, 4'h9, 8'h00, 8'h00);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_moves();
        t_addsub();
        t_cmp();
        t_logic();
        t_mul();
        t_divmod();
        t_divzero();
        t_unary();
        t_undefined();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule